// File: doc/BRIEF.md
# Ones'-Complement Add/Subtract Unit

This unit performs the arithmetic of an 18-bit accumulator machine that stores negative numbers as the bitwise complement of their magnitude. Each cycle it takes an accumulator operand, a memory operand, the current overflow flag and a two-bit operation code. One clock later it returns the result word, the new overflow flag and a skip request. The four operations are add, subtract, increment and increment-with-test. The carry out of the top bit is fed back into the low bit (end-around carry).

Add removes minus zero (all ones) from its result. Subtract does not. The overflow flag only ever gets set by add or subtract, and increments pass it through unchanged. The surrounding datapath owns the registers, the memory, the decoder and the program counter. It acts on the skip request as it sees fit.

Top module: `ocu_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `result` = 0, `ov_out` = 0 and `skip` = 0.
- R2: With `op` = 2'b00 (add), `result` is `acc_in + mem_in`. When that sum carries out of bit 17, the carry is added back into bit 0.
- R3: For add, `ov_out` is 1 when both operands share a sign bit and the end-around sum has the other sign. Otherwise `ov_out` equals `ov_in`, so an overflow of 1 stays 1.
- R4: For add, an end-around sum of all ones (minus zero) is given as 0. The overflow test in R3 is made before this replacement.
- R5: With `op` = 2'b01 (subtract), the unit first complements `acc_in` and adds `mem_in` with end-around carry. The result is the complement of that sum. Overflow is set by the R3 rule applied to the complemented accumulator and `mem_in`, and is otherwise kept.
- R6: Subtract does no minus-zero cleanup: 0777777 minus 0 gives 0777777.
- R7: With `op` = 2'b10 (increment) or 2'b11 (increment-and-test), `result` is `mem_in + 1`. If that value is all ones or more, one more is added and the result is kept to 18 bits. So 0777776 gives 0, and 0777777 gives 1.
- R8: `skip` is 1 only for `op` = 2'b11 with a result whose bit 17 is clear. It is 0 for every other operation.
- R9: Both increment operations give `ov_out` = `ov_in`.
- R10: Outputs change one clock edge after their inputs are sampled, and hold their value between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | 00 add, 01 subtract, 10 increment, 11 increment-and-test |
| acc_in | input | 18 | Accumulator operand |
| mem_in | input | 18 | Memory operand |
| ov_in | input | 1 | Current overflow flag |
| result | output | 18 | Registered result word |
| ov_out | output | 1 | Registered updated overflow flag |
| skip | output | 1 | Registered skip request |

## Verification
The hardest cases to reach are the ones where end-around carry and the minus-zero rules meet. Examples are an add whose end-around sum lands exactly on all ones, a subtract that must keep minus zero, and increments of 0777776 and 0777777. Random operands almost never produce these. A directed list places them on the ports, and each is run with the incoming overflow both clear and set, so the flag's stickiness is seen under the same operands. A pseudo-random stream then covers the ordinary cases against a wide-integer model.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_INC  = 2'b10,
    OP_INCT = 2'b11
  } ocu_op_e;
endpackage

// File: rtl/ocu_eac_add.sv
// End-around-carry adder with same-sign overflow detection.
module ocu_eac_add #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    sum = raw[W] ? (raw[W-1:0] + 1'b1) : raw[W-1:0];
    ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/ocu_incr.sv
// Increment with wrap past the all-ones code.
module ocu_incr #(
  parameter int W = 18
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] res
);
  localparam logic [W:0] ALL_ONES = {1'b0, {W{1'b1}}};
  logic [W:0] raw;

  always_comb begin
    raw = {1'b0, val} + 1'b1;
    res = (raw >= ALL_ONES) ? (raw[W-1:0] + 1'b1) : raw[W-1:0];
  end
endmodule

// File: rtl/ocu_alu.sv
module ocu_alu #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] mem_in,
  input  logic         ov_in,
  output logic [W-1:0] result,
  output logic         ov_out,
  output logic         skip
);
  import ocu_pkg::*;

  localparam logic [W-1:0] MZERO = {W{1'b1}};

  ocu_op_e      op_e;
  logic [W-1:0] add_sum, sub_sum, inc_res, acc_cpl;
  logic         add_ovf, sub_ovf;
  logic [W-1:0] res_d;
  logic         ov_d, skip_d;

  assign op_e    = ocu_op_e'(op);
  assign acc_cpl = ~acc_in;

  ocu_eac_add #(.W(W)) u_add (
    .a(acc_in), .b(mem_in), .sum(add_sum), .ovf(add_ovf)
  );

  ocu_eac_add #(.W(W)) u_sub (
    .a(acc_cpl), .b(mem_in), .sum(sub_sum), .ovf(sub_ovf)
  );

  ocu_incr #(.W(W)) u_inc (
    .val(mem_in), .res(inc_res)
  );

  always_comb begin
    res_d  = '0;
    ov_d   = ov_in;
    skip_d = 1'b0;
    unique case (op_e)
      OP_ADD: begin
        res_d = (add_sum == MZERO) ? '0 : add_sum;
        ov_d  = ov_in | add_ovf;
      end
      OP_SUB: begin
        res_d = ~sub_sum;
        ov_d  = ov_in | sub_ovf;
      end
      OP_INC: begin
        res_d = inc_res;
      end
      OP_INCT: begin
        res_d  = inc_res;
        skip_d = ~inc_res[W-1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      ov_out <= 1'b0;
      skip   <= 1'b0;
    end else begin
      result <= res_d;
      ov_out <= ov_d;
      skip   <= skip_d;
    end
  end
endmodule

// File: rtl/ocu_alu_chk.sv
module ocu_alu_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op,
  input logic         ov_in,
  input logic [W-1:0] result,
  input logic         ov_out,
  input logic         skip
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !ov_out && !skip)); // R1

  AST_OV_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ov_in)) |-> ov_out); // R3

  AST_ADD_NO_MZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'b00) |-> (result != {W{1'b1}})); // R4

  AST_SKIP_ONLY_TEST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) != 2'b11) |-> !skip); // R8

  AST_SKIP_SIGN: assert property (@(posedge clk) disable iff (rst)
    skip |-> !result[W-1]); // R8

  AST_INC_OV_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op[1])) |-> (ov_out == $past(ov_in))); // R9
endmodule

bind ocu_alu ocu_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .ov_in(ov_in),
  .result(result), .ov_out(ov_out), .skip(skip)
);

// File: tb/ocu_alu_bench.sv
module ocu_alu_bench;
  localparam int W = 18;
  localparam logic [W-1:0] M = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] acc_in = '0, mem_in = '0;
  logic         ov_in = 1'b0;
  logic [W-1:0] result;
  logic         ov_out, skip;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] r;
    logic         ov;
    logic         sk;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  ocu_alu #(.W(W)) u_ocu_alu (
    .clk(clk), .rst(rst), .op(op), .acc_in(acc_in), .mem_in(mem_in),
    .ov_in(ov_in), .result(result), .ov_out(ov_out), .skip(skip)
  );

  // Wide-integer model built from the requirements.
  function automatic exp_t model(input logic [1:0] o, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic ovi);
    exp_t e;
    longint s, t, mm;
    mm = longint'(M);
    e.ov = ovi; e.sk = 0;
    case (o)
      2'b00: begin
        s = longint'(a) + longint'(b);
        if (s > mm) s = (s + 1) & mm;
        if (a[W-1] == b[W-1] && s[W-1] != a[W-1]) e.ov = 1;
        if (s == mm) s = 0;
        e.r = s[W-1:0]; e.tag = "R2/R3/R4";
      end
      2'b01: begin
        t = longint'(a) ^ mm;
        s = t + longint'(b);
        if (s > mm) s = (s + 1) & mm;
        if (t[W-1] == b[W-1] && s[W-1] != t[W-1]) e.ov = 1;
        e.r = W'(s ^ mm); e.tag = "R5/R6";
      end
      default: begin
        s = longint'(b) + 1;
        if (s >= mm) s = (s + 1) & mm;
        e.r = s[W-1:0];
        if (o == 2'b11) e.sk = ~e.r[W-1];
        e.tag = "R7/R8/R9";
      end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [1:0] o, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic ovi, input string tag);
    exp_t e;
    @(negedge clk);
    op = o; acc_in = a; mem_in = b; ov_in = ovi;
    e = model(o, a, b, ovi);
    if (tag != "") e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic both(input logic [1:0] o, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string tag);
    drive(o, a, b, 1'b0, tag);
    drive(o, a, b, 1'b1, tag);
  endtask

  // Monitor: one register stage (R10), sample 1 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (result !== e.r || ov_out !== e.ov || skip !== e.sk) begin
          n_bad++;
          $display("FAIL %s: got r=%o ov=%b sk=%b expected r=%o ov=%b sk=%b",
                   e.tag, result, ov_out, skip, e.r, e.ov, e.sk);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    op = 2'b11; mem_in = 18'o000005; ov_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_chk++; // R1
    if (result !== '0 || ov_out !== 1'b0 || skip !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got r=%o ov=%b sk=%b expected r=0 ov=0 sk=0", result, ov_out, skip);
    end
    @(negedge clk);
    rst = 1'b0; op = 2'b00; acc_in = 18'o1; mem_in = 18'o2; ov_in = 1'b0;
    #5;
    n_chk++; // R10: still the reset value before the edge
    if (result !== '0) begin
      n_bad++;
      $display("FAIL R10: got r=%o expected r=0 before edge", result);
    end
    @(posedge clk); #1;
    n_chk++; // R10: updated after one edge
    if (result !== 18'o3) begin
      n_bad++;
      $display("FAIL R10: got r=%o expected r=3 after edge", result);
    end

    both(2'b00, 18'o000001, 18'o000002, "R2");
    both(2'b00, 18'o777775, 18'o000004, "R2");      // -2 + 4 end-around
    both(2'b00, 18'o377777, 18'o000001, "R3");      // positive overflow
    both(2'b00, 18'o400000, 18'o400000, "R3");      // negative overflow
    both(2'b00, 18'o777777, 18'o000000, "R4");      // -0 + 0 -> 0
    both(2'b00, 18'o000005, 18'o777772, "R4");      // 5 + -5 -> 0
    both(2'b01, 18'o000007, 18'o000003, "R5");
    both(2'b01, 18'o377777, 18'o400000, "R5");      // overflow on subtract
    both(2'b01, 18'o777777, 18'o000000, "R6");      // -0 - +0 stays -0
    both(2'b10, 18'o0, 18'o777776, "R7");           // -1 + 1 -> 0
    both(2'b10, 18'o0, 18'o777777, "R7");           // -0 + 1 -> 1
    both(2'b10, 18'o0, 18'o377777, "R9");
    both(2'b11, 18'o0, 18'o377777, "R8");           // goes negative, no skip
    both(2'b11, 18'o0, 18'o777776, "R8");           // reaches 0, skip
    both(2'b11, 18'o0, 18'o000010, "R8");
    both(2'b11, 18'o0, 18'o500000, "R8");

    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      begin
        logic [W-1:0] a, b;
        a = lfsr[W-1:0];
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        b = lfsr[W+3:4];
        drive(lfsr[1:0], a, b, lfsr[7], "");
      end
    end
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule